// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into a stream of element addresses, one per clock at best. A command carries a starting address, an addressing mode, a byte stride and an element count. The block accepts the command when it is idle. It then emits one address for each element over a valid/ready stream, together with the element number and the memory bank that the address falls in. Four modes are supported. Unit mode steps by one 8-byte word. Strided mode steps by a programmable byte distance. Indexed mode adds a byte offset taken from an index stream to the starting address, which serves gather and scatter. Sequence mode emits the plain multiples 0, m, 2m, … and is used to build index vectors.

Memory is split into 16 word-interleaved banks. After an access, each bank stays occupied for a fixed number of cycles. When the next address falls in an occupied bank, the stream waits until that bank is free. A stride that keeps returning to the same bank therefore thins the stream out, and a bank count larger than the occupancy time keeps unit-stride traffic gap-free. A one-cycle completion pulse follows the last address.

The asynchronous reset input is released inside the block through a two-stage synchronizer, so commands are taken from the third clock after reset deassertion onward.

Top module: `vec_agen`

## Requirements
- R1: While reset is asserted, and after its release until the first command, addr_valid, idx_ready, done and gen_busy are all low.
- R2: Mode code 0 (unit): element i is emitted at cmd_base + 8·i.
- R3: Mode code 1 (strided): element i is emitted at cmd_base + i·cmd_stride. The stride is a byte count in two's complement, and the sum wraps modulo 2^32.
- R4: Mode code 2 (indexed): element i is emitted at cmd_base + idx_data, where idx_data is the i-th index taken from the index stream. Exactly one index is consumed (idx_valid and idx_ready both high) per accepted address, and idx_ready is never high in any other mode.
- R5: Mode code 3 (sequence): element i is emitted as the value i·cmd_stride with no base added. This mode neither waits for nor occupies any bank.
- R6: addr_bank equals bits [6:3] of addr_out, which is the word address modulo 16.
- R7: Once an address in modes 0 to 2 is accepted for bank b, no further address for bank b is offered during the next 5 cycles. An address whose bank is free, and which is offered with addr_ready high, is accepted in the same cycle. As a result, a run whose elements all fall in one bank completes one element every 6 cycles.
- R8: A command emits exactly min(cmd_vlen, 64) addresses, numbered 0 upward on addr_elem. A length of 0 emits none.
- R9: done is high for exactly one cycle. That cycle is the one after the last address is accepted, or the one after the command is taken when the length is 0. gen_busy is high from the cycle after the command is taken through the done cycle, and low after it.
- R10: While addr_valid is high and addr_ready is low, addr_valid, addr_out and addr_elem keep their values into the next cycle.
- R11: cmd_start has no effect while gen_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command strobe, taken when idle |
| cmd_mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 sequence |
| cmd_base | input | 32 | Starting byte address |
| cmd_stride | input | 32 | Byte stride (modes 1 and 3) |
| cmd_vlen | input | 7 | Element count, clamped to 64 |
| idx_valid | input | 1 | Index stream valid |
| idx_data | input | 32 | Byte offset for the current element |
| idx_ready | output | 1 | Index consumed this cycle when valid |
| addr_valid | output | 1 | Address stream valid |
| addr_ready | input | 1 | Address stream ready |
| addr_out | output | 32 | Element address or sequence value |
| addr_bank | output | 4 | Bank of addr_out |
| addr_elem | output | 7 | Element number of addr_out |
| done | output | 1 | One-cycle completion pulse |
| gen_busy | output | 1 | A command is in progress |

## Verification
The hardest situation to reach from the ports is a bank hold that overlaps with downstream backpressure and an index stream, because the two kinds of waiting then interleave. The stimulus reaches it with chosen strides (256 bytes, which always hits one bank, and 32 bytes, which revisits a bank after four elements) and with index lists that return to bank 0 early. It runs these both with addr_ready held high, where the completion time is predicted exactly, and under a pseudo-random addr_ready. The bench also tracks the last use of every bank, so it can confirm that no bank is revisited too early.

// File: rtl/vec_agen_pkg.sv
package vec_agen_pkg;

  typedef enum logic [1:0] {
    AG_UNIT   = 2'd0,
    AG_STRIDE = 2'd1,
    AG_INDEX  = 2'd2,
    AG_SEQGEN = 2'd3
  } ag_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ag_state_e;

endpackage

// File: rtl/vec_agen_rsync.sv
module vec_agen_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vec_agen_ctrl.sv
module vec_agen_ctrl
  import vec_agen_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MAXVL      = 64,
  parameter int ELEM_BYTES = 8,
  localparam int LW        = $clog2(MAXVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_mode,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_stride,
  input  logic [LW-1:0] cmd_vlen,
  input  logic          step_fire,
  output logic          run_o,
  output logic          fin_o,
  output logic          idle_o,
  output ag_mode_e      mode_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] offs_o,
  output logic [LW-1:0] elem_o
);
  localparam logic [LW-1:0] VL_MAX = LW'(MAXVL);

  ag_state_e     st_q, st_d;
  ag_mode_e      mode_q;
  logic [AW-1:0] base_q, stride_q, offs_q, offs_d, step;
  logic [LW-1:0] vl_q, vl_clamp, elem_q, elem_d;
  logic          accept, adv, cnt_en;

  assign vl_clamp = (cmd_vlen > VL_MAX) ? VL_MAX : cmd_vlen;
  assign accept   = cmd_start && (st_q == ST_IDLE);
  assign adv      = step_fire && (st_q == ST_RUN);
  assign cnt_en   = accept || adv;
  assign step     = (mode_q == AG_UNIT) ? AW'(ELEM_BYTES) : stride_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    offs_d = offs_q;
    elem_d = elem_q;
    case (st_q)
      ST_IDLE: begin
        if (cmd_start) begin
          offs_d = '0;
          elem_d = '0;
          st_d   = (vl_clamp == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (step_fire) begin
          offs_d = offs_q + step;
          elem_d = elem_q + 1'b1;
          if (elem_d == vl_q) st_d = ST_FIN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= AG_UNIT;
      base_q   <= '0;
      stride_q <= '0;
      vl_q     <= '0;
    end else if (accept) begin
      mode_q   <= ag_mode_e'(cmd_mode);
      base_q   <= cmd_base;
      stride_q <= cmd_stride;
      vl_q     <= vl_clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '0;
      elem_q <= '0;
    end else if (cnt_en) begin
      offs_q <= offs_d;
      elem_q <= elem_d;
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_FIN);
  assign idle_o = (st_q == ST_IDLE);
  assign mode_o = mode_q;
  assign base_o = base_q;
  assign offs_o = offs_q;
  assign elem_o = elem_q;
endmodule

// File: rtl/vec_agen_bank.sv
module vec_agen_bank #(
  parameter int NBANK = 16,
  parameter int LAT   = 6,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark,
  input  logic [BW-1:0]    mark_bank,
  output logic [NBANK-1:0] busy
);
  localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit;

    assign hit = mark && (mark_bank == BW'(b));

    always_comb begin
      cnt_d = cnt_q;
      if (hit)               cnt_d = RELOAD;
      else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign busy[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/vec_agen.sv
module vec_agen
  import vec_agen_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MAXVL      = 64,
  parameter int ELEM_BYTES = 8,
  parameter int NBANK      = 16,
  parameter int BANK_LAT   = 6,
  localparam int LW        = $clog2(MAXVL + 1),
  localparam int BW        = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_mode,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_stride,
  input  logic [LW-1:0] cmd_vlen,
  input  logic          idx_valid,
  input  logic [AW-1:0] idx_data,
  output logic          idx_ready,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out,
  output logic [BW-1:0] addr_bank,
  output logic [LW-1:0] addr_elem,
  output logic          done,
  output logic          gen_busy
);
  localparam int WSH = $clog2(ELEM_BYTES);

  logic             rst_i_n;
  logic             run, fin, idle;
  ag_mode_e         mode_q;
  logic [AW-1:0]    base_q, offs_q, add_a, add_b, addr_w;
  logic [LW-1:0]    elem_q;
  logic [BW-1:0]    bank_w;
  logic [NBANK-1:0] busy_vec;
  logic             idx_mode, seq_mode, src_ok, hit, fire, bank_mark;

  vec_agen_rsync u_rsync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  vec_agen_ctrl #(
    .AW        (AW),
    .MAXVL     (MAXVL),
    .ELEM_BYTES(ELEM_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cmd_start (cmd_start),
    .cmd_mode  (cmd_mode),
    .cmd_base  (cmd_base),
    .cmd_stride(cmd_stride),
    .cmd_vlen  (cmd_vlen),
    .step_fire (fire),
    .run_o     (run),
    .fin_o     (fin),
    .idle_o    (idle),
    .mode_o    (mode_q),
    .base_o    (base_q),
    .offs_o    (offs_q),
    .elem_o    (elem_q)
  );

  // address formation and bank selection
  assign idx_mode = (mode_q == AG_INDEX);
  assign seq_mode = (mode_q == AG_SEQGEN);
  assign add_a    = seq_mode ? '0 : base_q;
  assign add_b    = idx_mode ? idx_data : offs_q;
  assign addr_w   = add_a + add_b;
  assign bank_w   = addr_w[WSH +: BW];

  vec_agen_bank #(
    .NBANK(NBANK),
    .LAT  (BANK_LAT)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .mark     (bank_mark),
    .mark_bank(bank_w),
    .busy     (busy_vec)
  );

  // stream handshake
  assign hit        = busy_vec[bank_w] && !seq_mode;
  assign src_ok     = !idx_mode || idx_valid;
  assign addr_valid = run && src_ok && !hit;
  assign idx_ready  = run && idx_mode && addr_ready && !hit;
  assign fire       = addr_valid && addr_ready;
  assign bank_mark  = fire && !seq_mode;

  assign addr_out  = addr_w;
  assign addr_bank = bank_w;
  assign addr_elem = elem_q;
  assign done      = fin;
  assign gen_busy  = !idle;
endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk #(
  parameter int AW       = 32,
  parameter int LW       = 7,
  parameter int BW       = 4,
  parameter int NBANK    = 16,
  parameter int BANK_LAT = 6,
  localparam int SW      = $clog2(BANK_LAT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_out,
  input logic [BW-1:0] addr_bank,
  input logic [LW-1:0] addr_elem,
  input logic          done,
  input logic          gen_busy,
  input logic          bank_mark
);
  localparam logic [SW-1:0] SAT = SW'(BANK_LAT);

  logic [SW-1:0] since [NBANK];
  logic          fire;

  assign fire = addr_valid && addr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) since[b] <= SAT;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_mark && (addr_bank == BW'(b))) since[b] <= SW'(1);
        else if (since[b] < SAT)                since[b] <= since[b] + 1'b1;
      end
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out) && $stable(addr_elem)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !gen_busy));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_busy |-> (!addr_valid && !done));

  // R8
  elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (addr_elem == $past(addr_elem) + 1'b1));

  // R7
  bank_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_mark |-> (since[addr_bank] >= SAT));
endmodule

bind vec_agen vec_agen_chk #(
  .AW      (AW),
  .LW      (LW),
  .BW      (BW),
  .NBANK   (NBANK),
  .BANK_LAT(BANK_LAT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_valid(addr_valid),
  .addr_ready(addr_ready),
  .addr_out  (addr_out),
  .addr_bank (addr_bank),
  .addr_elem (addr_elem),
  .done      (done),
  .gen_busy  (gen_busy),
  .bank_mark (bank_mark)
);

// File: tb/vec_agen_tb_top.sv
module vec_agen_tb_top;
  localparam int LAT = 6;

  logic        clk;
  logic        rst_n;
  logic        cmd_start;
  logic [1:0]  cmd_mode;
  logic [31:0] cmd_base, cmd_stride;
  logic [6:0]  cmd_vlen;
  logic        idx_valid;
  logic [31:0] idx_data;
  logic        idx_ready;
  logic        addr_valid;
  logic        addr_ready;
  logic [31:0] addr_out;
  logic [3:0]  addr_bank;
  logic [6:0]  addr_elem;
  logic        done;
  logic        gen_busy;

  vec_agen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mode(cmd_mode),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
    .idx_valid(idx_valid), .idx_data(idx_data), .idx_ready(idx_ready),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .addr_bank(addr_bank), .addr_elem(addr_elem), .done(done), .gen_busy(gen_busy)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [3:0]  b;
    logic [6:0]  e;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] idx_q[$];
  logic [31:0] idx_src [64];
  int          last_use [16];
  int          n_chk, n_fail, cyc, done_cyc, done_cnt, last_fire_cyc, cur_mode, dur;
  bit          bp_en, zero_len, finished;
  logic [15:0] lfsr;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4";
      default: return "R5";
    endcase
  endfunction

  // monitor and stream-side driver
  initial begin
    bit          held_v, prev_done, take;
    logic [31:0] held_a;
    logic [6:0]  held_e;
    exp_t        e;
    held_v = 0; prev_done = 0;
    addr_ready = 1'b1; idx_valid = 1'b0; idx_data = '0; lfsr = 16'hACE1;
    for (int b = 0; b < 16; b++) last_use[b] = -100;
    done_cnt = 0; last_fire_cyc = -100;
    forever begin
      @(negedge clk);
      take = 0;
      if (rst_n) begin
        if (held_v)
          chk(addr_valid && addr_out == held_a && addr_elem == held_e, "R10",
              "held address changed", addr_out, held_a);
        held_v = addr_valid && !addr_ready;
        held_a = addr_out;
        held_e = addr_elem;
        if (cur_mode != 2 && idx_ready)
          chk(0, "R4", "idx_ready outside indexed mode", 1, 0);
        if (addr_valid && addr_ready) begin
          if (exp_q.size() == 0) begin
            chk(0, "R8", "address beyond vector length", addr_out, 0);
          end else begin
            e = exp_q.pop_front();
            chk(addr_out == e.a, mode_req(cur_mode), "address", addr_out, e.a);
            chk(addr_bank == e.b, "R6", "bank", addr_bank, e.b);
            chk(addr_elem == e.e, "R8", "element number", addr_elem, e.e);
          end
          if (cur_mode != 2'd3) begin
            chk(cyc - last_use[addr_bank] >= LAT, "R7", "bank reused too early",
                cyc - last_use[addr_bank], LAT);
            last_use[addr_bank] = cyc;
          end
          last_fire_cyc = cyc;
        end
        if (prev_done) chk(!done, "R9", "done longer than one cycle", done, 0);
        if (done) begin
          done_cyc = cyc;
          done_cnt++;
          chk(exp_q.size() == 0, "R8", "addresses missing at done", exp_q.size(), 0);
          if (!zero_len)
            chk(last_fire_cyc == cyc - 1, "R9", "done not right after last address",
                last_fire_cyc, cyc - 1);
        end
        prev_done = done;
        take = idx_valid && idx_ready;
      end
      @(posedge clk);
      #1;
      if (take) void'(idx_q.pop_front());
      idx_valid = (idx_q.size() > 0);
      idx_data  = (idx_q.size() > 0) ? idx_q[0] : '0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      addr_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  task automatic run_cmd(input int mode, input logic [31:0] base, input logic [31:0] stride,
                         input int vlen, input bit poke, output int d);
    int n, t_start, dc0;
    n = (vlen > 64) ? 64 : vlen;
    for (int i = 0; i < n; i++) begin
      exp_t        x;
      logic [31:0] a;
      case (mode)
        0:       a = base + 32'(i) * 32'd8;
        1:       a = base + 32'(i) * stride;
        2:       a = base + idx_src[i];
        default: a = 32'(i) * stride;
      endcase
      x.a = a; x.b = a[6:3]; x.e = 7'(i);
      exp_q.push_back(x);
    end
    if (mode == 2) for (int i = 0; i < n; i++) idx_q.push_back(idx_src[i]);
    cur_mode = mode;
    zero_len = (n == 0);
    @(negedge clk);
    cmd_mode = 2'(mode); cmd_base = base; cmd_stride = stride; cmd_vlen = 7'(vlen);
    cmd_start = 1'b1; t_start = cyc; dc0 = done_cnt;
    @(negedge clk);
    cmd_start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      cmd_start = 1'b1; cmd_base = 32'hDEAD_0000; cmd_mode = 2'd3; cmd_vlen = 7'd3;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    while (done_cnt == dc0) @(negedge clk);
    d = done_cyc - t_start;
    repeat (8) @(negedge clk);
    chk(!gen_busy, "R9", "gen_busy after done", gen_busy, 0);
    chk(exp_q.size() == 0, "R8", "expected addresses left", exp_q.size(), 0);
    if (mode == 2) chk(idx_q.size() == 0, "R4", "indices left unconsumed", idx_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_mode = '0; cmd_base = '0; cmd_stride = '0;
    cmd_vlen = '0; bp_en = 0; zero_len = 0; cur_mode = 0; finished = 0;
    n_chk = 0; n_fail = 0; done_cyc = 0;
    repeat (3) @(negedge clk);
    chk(!addr_valid, "R1", "addr_valid in reset", addr_valid, 0);
    chk(!idx_ready, "R1", "idx_ready in reset", idx_ready, 0);
    chk(!done, "R1", "done in reset", done, 0);
    chk(!gen_busy, "R1", "gen_busy in reset", gen_busy, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!addr_valid && !done && !gen_busy, "R1", "outputs after release",
        {addr_valid, done, gen_busy}, 0);

    // R2: unit stride, no bank stall
    run_cmd(0, 32'h0000_1000, 32'd0, 20, 0, dur);
    chk(dur == 21, "R7", "unit stride run time", dur, 21);
    // R3: stride of 3 words, all banks distinct
    run_cmd(1, 32'h0000_2008, 32'd24, 10, 0, dur);
    chk(dur == 11, "R3", "stride 24 run time", dur, 11);
    // R3: negative stride wrapping below zero
    run_cmd(1, 32'h0000_0010, 32'hFFFF_FFF8, 12, 0, dur);
    chk(dur == 13, "R3", "negative stride run time", dur, 13);
    // R7: every element in one bank
    run_cmd(1, 32'h0000_0040, 32'd256, 5, 0, dur);
    chk(dur == 4 * LAT + 2, "R7", "same-bank run time", dur, 4 * LAT + 2);
    // R7: bank revisited after four elements
    run_cmd(1, 32'h0000_0000, 32'd32, 8, 0, dur);
    chk(dur == 11, "R7", "stride 32 run time", dur, 11);
    // R4: gather list with bank 0 revisited early
    idx_src[0] = 32'h000; idx_src[1] = 32'h048; idx_src[2] = 32'h090; idx_src[3] = 32'h018;
    idx_src[4] = 32'h080; idx_src[5] = 32'h1F8; idx_src[6] = 32'h008; idx_src[7] = 32'h100;
    run_cmd(2, 32'h0000_3000, 32'd0, 8, 0, dur);
    chk(dur == 14, "R4", "gather run time", dur, 14);
    // R5: sequence values, no bank effect
    run_cmd(3, 32'h0000_5555, 32'd256, 10, 0, dur);
    chk(dur == 11, "R5", "sequence run time", dur, 11);
    // R8: zero length
    run_cmd(0, 32'h0000_0000, 32'd0, 0, 0, dur);
    chk(dur == 1, "R9", "zero-length done timing", dur, 1);
    // R8: length clamp
    run_cmd(0, 32'h0000_0000, 32'd0, 100, 0, dur);
    chk(dur == 65, "R8", "clamped run time", dur, 65);
    // R11: start during a run
    run_cmd(0, 32'h0000_8000, 32'd0, 16, 1, dur);
    chk(dur == 17, "R11", "run time with stray start", dur, 17);

    // R10: backpressure on several modes
    bp_en = 1;
    run_cmd(1, 32'h0001_0000, 32'd40, 30, 0, dur);
    for (int i = 0; i < 12; i++) idx_src[i] = 32'(i * 72) & 32'h3F8;
    run_cmd(2, 32'h0002_0000, 32'd0, 12, 0, dur);
    run_cmd(1, 32'h0000_0000, 32'd32, 20, 0, dur);
    run_cmd(0, 32'h0003_0100, 32'd0, 25, 0, dur);
    bp_en = 0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "R9", "watchdog expired", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule